// File: doc/BRIEF.md
# Banked Byte Store with Page Load Buffer and Block Write Protection

This block sits behind a serial bus front end and owns a 512-byte store. The store is split into two 256-byte banks, and only the active bank can be seen. The front end decodes the bus and passes one command per cycle: load the byte pointer, push a write byte, signal the end of a transfer, fetch the next read byte, choose the bank, request that a protection flag be set, or request that all protection flags be cleared. Write bytes collect in a 16-byte load buffer. They reach the store only during a timed commit cycle that the end-of-transfer command starts.

Each bank is split into two halves of 128 bytes, which gives four protection blocks, one flag per block. Which flag guards a write depends on both the active bank and the top bit of the byte address. While a commit cycle runs, the `busy` output is high and every command is dropped, so the front end can decline to acknowledge its address. The commit length is a parameter counted in clock cycles. A short value keeps simulations fast, and a long value matches a real write time.

Top module: `bnk_eeprom_wp_ctrl`

## Requirements
- R1: After reset, `bank_sel` is 0, `wp_flags` is 4'b0000, `busy` is 0, `rd_valid` is 0, and the byte pointer is 0x00, so the first read returns byte 0x00 of bank 0.
- R2: Command codes on `cmd_op` are: 0 load pointer, 1 write byte, 2 end of transfer, 3 read byte, 4 set flag, 5 clear all flags, 6 choose bank, 7 no operation. The load-pointer command sets the pointer to `cmd_data`. Pointer bits 7:4 select one of 16 pages and bits 3:0 select the byte within that page.
- R3: Each write byte lands at the current in-page position, and the position then advances modulo 16 while the page stays the same. A seventeenth or later byte overwrites the byte loaded 16 positions earlier.
- R4: Buffered bytes reach the store only after an end-of-transfer command. When one is accepted, `busy` is high from the next cycle for exactly WR_CYCLES cycles.
- R5: While `busy` is high, every command is ignored: no read data appears, and the pointer, bank, flags and buffer are left unchanged.
- R6: A read command returns the byte at {bank, pointer} on `rd_data`, with `rd_valid` high in the following cycle. The pointer then advances by one and wraps from 0xFF to 0x00 inside the active bank.
- R7: The choose-bank command sets the active bank to `cmd_data[0]`. The two banks hold independent contents at equal addresses.
- R8: The protection block index is {bank, pointer[7]}, and it is also the bit position in `wp_flags`. A transfer whose block flag is set writes nothing to the store and does not raise `busy`.
- R9: The set-flag command names a block in `cmd_data[1:0]`. At the next end of transfer, if that flag was clear, the flag is set and a commit cycle runs. If the flag was already set, nothing happens and `busy` stays low. A clear-all request always clears the flags and runs a commit cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_data | input | 8 | Address, data byte, block number or bank |
| rd_valid | output | 1 | `rd_data` holds a read byte |
| rd_data | output | 8 | Byte returned by a read command |
| busy | output | 1 | Commit cycle in progress; commands are dropped |
| bank_sel | output | 1 | Active bank |
| wp_flags | output | 4 | Protection flags, bit i guards block i |

## Verification
On every cycle, assertions check the following:
- A store write only ever happens during a commit cycle.
- A store write never targets a protected block.
- The in-page load never moves the page.
- The bank and flags stay stable while busy, and a flag only falls after an accepted clear-all.
- Read data appears only after an accepted read command.

Only the scenarios can show the rest:
- The exact length of a commit cycle.
- The wrap-around overwrite order in the load buffer.
- The wrap of the read pointer at the bank boundary.
- The separation between the two banks.
- That a refused or repeated protection request leaves the stored bytes and `busy` untouched.

// File: rtl/eepwp_pkg.sv
package eepwp_pkg;

  localparam int EEP_DW   = 8;   // byte width
  localparam int EEP_AW   = 8;   // byte address inside one bank
  localparam int EEP_PW   = 4;   // in-page offset width
  localparam int EEP_NBLK = 4;   // protection blocks

  typedef enum logic [2:0] {
    OP_ADDR  = 3'd0,
    OP_WDATA = 3'd1,
    OP_STOP  = 3'd2,
    OP_READ  = 3'd3,
    OP_SETWP = 3'd4,
    OP_CLRWP = 3'd5,
    OP_BANK  = 3'd6,
    OP_NONE  = 3'd7
  } eep_op_e;

  // protection block that guards a byte: active bank and upper half bit
  function automatic logic [1:0] prot_block(input logic bank, input logic [EEP_AW-1:0] addr);
    return {bank, addr[EEP_AW-1]};
  endfunction

  // load position: offset wraps, page stays
  function automatic logic [EEP_AW-1:0] load_next(input logic [EEP_AW-1:0] a);
    return {a[EEP_AW-1:EEP_PW], a[EEP_PW-1:0] + {{(EEP_PW-1){1'b0}}, 1'b1}};
  endfunction

  // read position: whole bank address wraps
  function automatic logic [EEP_AW-1:0] read_next(input logic [EEP_AW-1:0] a);
    return a + {{(EEP_AW-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/eepwp_store.sv
module eepwp_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/eepwp_ldbuf.sv
module eepwp_ldbuf #(
  parameter int PW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [PW-1:0] ld_pos,
  input  logic [DW-1:0] ld_data,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_byte,
  output logic          rd_mark,
  output logic          any_loaded
);
  localparam int NB = 1 << PW;

  logic [DW-1:0] bytes_q [NB];
  logic [NB-1:0] mark_q;

  always_ff @(posedge clk) begin
    if (ld) bytes_q[ld_pos] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   mark_q <= '0;
    else if (clr) mark_q <= '0;
    else if (ld)  mark_q[ld_pos] <= 1'b1;
  end

  assign rd_byte    = bytes_q[rd_idx];
  assign rd_mark    = mark_q[rd_idx];
  assign any_loaded = |mark_q;

  // R3: a loaded byte is always marked for commit
  a_r3_load_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> mark_q[$past(ld_pos)]);
endmodule

// File: rtl/eepwp_wtimer.sv
module eepwp_wtimer #(
  parameter int CYC = 32,
  parameter int PW  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        step_live,
  output logic [PW:0] step
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int NB = 1 << PW;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [PW:0]   step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (start) begin
      cnt_q  <= CW'(CYC - 1);
      busy_q <= 1'b1;
      step_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (step_q != (PW+1)'(NB)) step_q <= step_q + 1'b1;
    end
  end

  assign busy      = busy_q;
  assign done      = busy_q && (cnt_q == '0);
  assign step      = step_q;
  assign step_live = busy_q && !step_q[PW];

  // R4: an accepted start always produces a busy cycle
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R5: no new commit can begin while one is running
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/bnk_eeprom_wp_ctrl.sv
module bnk_eeprom_wp_ctrl
  import eepwp_pkg::*;
#(
  parameter int WR_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [EEP_DW-1:0] cmd_data,
  output logic              rd_valid,
  output logic [EEP_DW-1:0] rd_data,
  output logic              busy,
  output logic              bank_sel,
  output logic [EEP_NBLK-1:0] wp_flags
);
  localparam int SAW = EEP_AW + 1;   // bank bit plus byte address
  localparam int PGW = EEP_AW - EEP_PW;

  eep_op_e op;
  assign op = eep_op_e'(cmd_op);

  logic              take, stop_take;
  logic [EEP_AW-1:0] ptr_q;
  logic              bank_q;
  logic [EEP_NBLK-1:0] wp_q;
  logic              pend_set, pend_clr;
  logic [1:0]        pend_blk;
  logic              cm_bank;
  logic [PGW-1:0]    cm_page;
  logic              set_go, clr_go, data_go, start;
  logic              buf_clr, buf_ld, any_loaded;
  logic [EEP_DW-1:0] buf_byte;
  logic              buf_mark;
  logic              wt_done, step_live;
  logic [EEP_PW:0]   step;
  logic              mem_we, mem_re;
  logic [1:0]        data_blk;
  logic              rd_valid_q;

  assign take      = cmd_valid && !busy;
  assign stop_take = take && (op == OP_STOP);
  assign data_blk  = prot_block(bank_q, ptr_q);

  assign clr_go  = stop_take && pend_clr;
  assign set_go  = stop_take && pend_set && !pend_clr && !wp_q[pend_blk];
  assign data_go = stop_take && !pend_set && !pend_clr && any_loaded && !wp_q[data_blk];
  assign start   = set_go || clr_go || data_go;

  assign buf_ld  = take && (op == OP_WDATA);
  assign buf_clr = (take && op == OP_ADDR) || (stop_take && !data_go) || wt_done;
  assign mem_re  = take && (op == OP_READ);
  assign mem_we  = step_live && buf_mark;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      bank_q   <= 1'b0;
      wp_q     <= '0;
      pend_set <= 1'b0;
      pend_clr <= 1'b0;
      pend_blk <= '0;
      cm_bank  <= 1'b0;
      cm_page  <= '0;
    end else if (take) begin
      unique case (op)
        OP_ADDR: begin
          ptr_q    <= cmd_data;
          pend_set <= 1'b0;
          pend_clr <= 1'b0;
        end
        OP_WDATA: ptr_q <= load_next(ptr_q);
        OP_READ:  ptr_q <= read_next(ptr_q);
        OP_SETWP: begin
          pend_set <= 1'b1;
          pend_blk <= cmd_data[1:0];
        end
        OP_CLRWP: pend_clr <= 1'b1;
        OP_BANK:  bank_q <= cmd_data[0];
        OP_STOP: begin
          pend_set <= 1'b0;
          pend_clr <= 1'b0;
          if (clr_go)      wp_q <= '0;
          else if (set_go) wp_q[pend_blk] <= 1'b1;
          if (data_go) begin
            cm_bank <= bank_q;
            cm_page <= ptr_q[EEP_AW-1:EEP_PW];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= mem_re;
  end

  eepwp_ldbuf #(.PW(EEP_PW), .DW(EEP_DW)) i_ldbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .ld(buf_ld),
    .ld_pos(ptr_q[EEP_PW-1:0]), .ld_data(cmd_data),
    .rd_idx(step[EEP_PW-1:0]), .rd_byte(buf_byte), .rd_mark(buf_mark),
    .any_loaded(any_loaded)
  );

  eepwp_wtimer #(.CYC(WR_CYCLES), .PW(EEP_PW)) i_wtimer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(wt_done),
    .step_live(step_live), .step(step)
  );

  eepwp_store #(.AW(SAW), .DW(EEP_DW)) i_store (
    .clk(clk), .we(mem_we),
    .waddr({cm_bank, cm_page, step[EEP_PW-1:0]}), .wdata(buf_byte),
    .re(mem_re), .raddr({bank_q, ptr_q}), .rdata(rd_data)
  );

  assign rd_valid = rd_valid_q;
  assign bank_sel = bank_q;
  assign wp_flags = wp_q;

  // R4: the store is written only inside a commit cycle
  a_r4_write_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R8: a store write never lands in a protected block
  a_r8_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp_q[{cm_bank, cm_page[PGW-1]}]);
  // R3: loading a byte keeps the page
  a_r3_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ld |=> ptr_q[EEP_AW-1:EEP_PW] == $past(ptr_q[EEP_AW-1:EEP_PW]));
  // R6: read data only follows an accepted read command
  a_r6_read_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_op == 3'd3 && !busy));
  // R5: bank and flags hold while busy
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bank_q) && $stable(wp_q));
  // R9: a flag falls only through an accepted clear-all
  a_r9_flag_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(wp_q) & ~wp_q)) |-> $past(clr_go));
endmodule

// File: tb/test_bnk_eeprom_wp_ctrl.sv
`timescale 1ns/1ps
module test_bnk_eeprom_wp_ctrl;
  localparam int WRC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd7;
  logic [7:0] cmd_data = 8'h00;
  logic       rd_valid, busy, bank_sel;
  logic [7:0] rd_data;
  logic [3:0] wp_flags;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  bnk_eeprom_wp_ctrl #(.WR_CYCLES(WRC)) i_bnk_eeprom_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .bank_sel(bank_sel), .wp_flags(wp_flags)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5: actual read %0h expected no read", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    send(3'd3, 8'h00);
  endtask

  // ends the transfer and returns how many sampled cycles busy stayed high
  task automatic stop_count(output int n);
    send(3'd2, 8'h00);
    idle();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic wr_page(input logic [7:0] a, input logic [7:0] b0, input int cnt);
    int n;
    send(3'd0, a);
    for (int i = 0; i < cnt; i++) send(3'd1, b0 + 8'(i));
    stop_count(n);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 bank", bank_sel, 0);
    check("R1 flags", wp_flags, 0);
    check("R1 rd_valid", rd_valid, 0);

    // R2 / R4: write four bytes at 0x10, count busy
    send(3'd0, 8'h10);
    for (int i = 0; i < 4; i++) send(3'd1, 8'hA0 + 8'(i));
    idle();
    check("R4 no busy before stop", busy, 0);
    stop_count(n);
    check("R4 busy length", n, WRC);
    send(3'd0, 8'h10);
    for (int i = 0; i < 4; i++) rd(8'hA0 + 8'(i), "R2 readback");
    idle();

    // R3: 18 bytes from 0x2E wrap inside page 2
    wr_page(8'h2E, 8'h50, 18);
    send(3'd0, 8'h20);
    for (int p = 0; p < 16; p++) begin
      automatic logic [7:0] e;
      if (p == 14)      e = 8'h50 + 8'd16;
      else if (p == 15) e = 8'h50 + 8'd17;
      else              e = 8'h50 + 8'(p + 2);
      rd(e, "R3 wrap overwrite");
    end
    idle();

    // R5: commands during busy are dropped
    send(3'd0, 8'h40);
    send(3'd1, 8'hB0);
    send(3'd2, 8'h00);
    send(3'd3, 8'h00);
    send(3'd0, 8'h10);
    send(3'd1, 8'hEE);
    send(3'd6, 8'h01);
    send(3'd2, 8'h00);
    idle();
    check("R5 still busy", busy, 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R5 no extra commit", busy, 0);
    check("R5 bank kept", bank_sel, 0);
    send(3'd0, 8'h10);
    rd(8'hA0, "R5 data kept");
    send(3'd0, 8'h40);
    rd(8'hB0, "R5 commit before busy");
    idle();

    // R6: read wraps at end of bank
    wr_page(8'hFE, 8'hC0, 2);
    wr_page(8'h00, 8'hC2, 2);
    send(3'd0, 8'hFE);
    for (int i = 0; i < 4; i++) rd(8'hC0 + 8'(i), "R6 bank wrap");
    idle();

    // R7: bank 1 has own contents
    send(3'd6, 8'h01);
    idle();
    check("R7 bank one", bank_sel, 1);
    wr_page(8'h10, 8'hD0, 1);
    send(3'd0, 8'h10);
    rd(8'hD0, "R7 bank one data");
    send(3'd6, 8'h00);
    send(3'd0, 8'h10);
    rd(8'hA0, "R7 bank zero data");
    idle();

    // R9 / R8: protect block 1 (bank 0 upper half)
    send(3'd4, 8'h01);
    stop_count(n);
    check("R9 set flag cycle", n, WRC);
    check("R9 flags", wp_flags, 4'b0010);
    send(3'd0, 8'hFE);
    send(3'd1, 8'h77);
    stop_count(n);
    check("R8 protected no busy", n, 0);
    send(3'd0, 8'hFE);
    rd(8'hC0, "R8 protected data kept");
    send(3'd6, 8'h01);
    idle();
    wr_page(8'h90, 8'hE5, 1);
    send(3'd0, 8'h90);
    rd(8'hE5, "R8 block depends on bank");
    send(3'd6, 8'h00);
    send(3'd4, 8'h01);
    stop_count(n);
    check("R9 repeat set no cycle", n, 0);
    send(3'd5, 8'h00);
    stop_count(n);
    check("R9 clear cycle", n, WRC);
    check("R9 cleared", wp_flags, 0);
    wr_page(8'hFE, 8'h88, 1);
    send(3'd0, 8'hFE);
    rd(8'h88, "R9 write after clear");
    idle();

    // R1: reset returns bank, flags and pointer
    send(3'd6, 8'h01);
    send(3'd4, 8'h00);
    stop_count(n);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bank after reset", bank_sel, 0);
    check("R1 flags after reset", wp_flags, 0);
    rd(8'hC2, "R1 pointer zero");
    idle();
    repeat (4) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule